// File: doc/BRIEF.md
# Row/Column Strobe Controller for Asynchronous DRAM

This block sits between a clocked host and an asynchronous DRAM whose address pins are shared by the row and the column, and whose row and column strobes are active low. The host presents one request at a time on a valid/ready handshake: a read or write flag, a full word address and write data. The controller cuts the address into a row part (upper `ROW_BITS`) and a column part (lower `COL_BITS`) and places each on the shared pins in turn. It then drives the strobes with every interval counted in clock cycles.

After an access the row stays open. A further request to the same row pulses only the column strobe. A request to another row first closes the page and waits out the precharge time. The page is also closed before the row strobe has been low for too long. A free-running timer asks for a refresh at a fixed period. The refresh is a row-strobe-only access to a row taken from a wrapping counter. While it is waiting or running, the host is held off.

Top module: `dramc_ctrl`

## Requirements
- R1: During reset and on leaving it, `dram_ras_n`, `dram_cas_n` and `dram_we_n` are 1, `dram_dq_oe` and `rsp_valid` are 0. The row strobe stays high for at least `T_RP` cycles after reset before its first fall.
- R2: The row strobe falls only after it has been high for at least `T_RP` consecutive cycles. Its row address is on `dram_addr` in the cycle before the fall and unchanged in the cycle of the fall.
- R3: The column strobe is low only while the row strobe is low. It falls at least `T_RCD` cycles after the row strobe fell, and `dram_addr` holds the column in the cycle before its fall and in the cycle of the fall.
- R4: For a write, `dram_we_n` is 0 and `dram_dq_oe` is 1 with the write data on `dram_dq_out` from the cycle before the column strobe falls until it rises. `dram_we_n` is 0 only while the row strobe is low.
- R5: For a read, `rsp_valid` is high for exactly one cycle, `T_CAS` cycles after the column strobe fell. `rsp_rdata` then holds the value of `dram_dq_in` sampled while the strobe was still low.
- R6: A request whose row equals the open row is served without a new row strobe fall; only the column strobe is pulsed.
- R7: A request to a different row closes the page (row strobe high), waits `T_RP` cycles and opens the new row.
- R8: A refresh is requested every `REFRESH_INTERVAL` cycles. It is served as a row strobe low period with no column strobe fall. The refreshed rows are 0, 1, 2, … and wrap at 2^`ROW_BITS`.
- R9: `req_ready` is 0 from the moment a refresh is pending until the refresh row access has ended.
- R10: The row strobe never stays low for more than `T_RAS_MAX` consecutive cycles. An open page is closed in time even while requests to it keep arriving.
- R11: A request is taken on a cycle with `req_valid` and `req_ready` both 1. The row is `req_addr[ROW_BITS+COL_BITS-1:COL_BITS]` and the column is `req_addr[COL_BITS-1:0]`, each zero-extended onto `dram_addr`. Requests are served in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller can take the request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ROW_BITS+COL_BITS | Word address, row in the upper part |
| req_wdata | input | DATA_W | Write data |
| rsp_valid | output | 1 | One-cycle read data strobe |
| rsp_rdata | output | DATA_W | Read data |
| dram_addr | output | max(ROW_BITS,COL_BITS) | Shared row/column address pins |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 1 | Column strobe, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_dq_oe | output | 1 | Drive enable for the data pins |
| dram_dq_out | output | DATA_W | Data to the memory |
| dram_dq_in | input | DATA_W | Data from the memory |

## Verification
The bench builds the controller with 4 row bits, 4 column bits, 8 data bits, `T_RCD`=2, `T_CAS`=2, `T_RP`=3, `T_RAS_MAX`=20 and `REFRESH_INTERVAL`=150. With a 16×16 array the top and bottom rows and columns are cheap to reach. A `T_RAS_MAX` of 20 lets a run of six reads to one row force a page close after about three column pulses. The short refresh period yields several refreshes, each with its row number, inside a short run, and makes refreshes cut into page traffic.

// File: rtl/dramc_pkg.sv
package dramc_pkg;

   typedef enum logic [2:0] {
      ST_PRE,
      ST_IDLE,
      ST_RSETUP,
      ST_ROW,
      ST_CSETUP,
      ST_COL,
      ST_OPEN,
      ST_REF
   } dramc_state_e;

   function automatic int max2(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/dramc_wait_cnt.sv
module dramc_wait_cnt #(
   parameter int MAX_LOAD  = 4,
   parameter int RESET_VAL = 0,
   localparam int W = $clog2(MAX_LOAD + 1)
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] load_val,
   output logic         zero
);

   logic [W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n)
         cnt_q <= W'(RESET_VAL);
      else if (load)
         cnt_q <= load_val;
      else if (cnt_q != '0)
         cnt_q <= cnt_q - 1'b1;
   end

   assign zero = (cnt_q == '0);

endmodule

// File: rtl/dramc_refresh_sched.sv
module dramc_refresh_sched #(
   parameter int INTERVAL = 780,
   parameter int ROW_BITS = 10
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                take,
   input  logic                done,
   output logic                pending,
   output logic [ROW_BITS-1:0] row
);

   localparam int TW = $clog2(INTERVAL);

   logic [TW-1:0] tmr_q;
   logic          tick;

   assign tick = (tmr_q == TW'(INTERVAL - 1));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         tmr_q   <= '0;
         pending <= 1'b0;
         row     <= '0;
      end else begin
         tmr_q <= tick ? '0 : tmr_q + 1'b1;
         if (tick)
            pending <= 1'b1;
         else if (take)
            pending <= 1'b0;
         if (done)
            row <= row + 1'b1;
      end
   end

endmodule

// File: rtl/dramc_ras_age.sv
module dramc_ras_age #(
   parameter int T_RAS_MAX = 1000,
   parameter int T_CAS     = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic ras_n,
   output logic hit_ok
);

   localparam int AW = $clog2(T_RAS_MAX + 1) + 1;

   logic [AW-1:0] age_q;

   always_ff @(posedge clk) begin
      if (!rst_n || ras_n)
         age_q <= '0;
      else if (int'(age_q) < T_RAS_MAX)
         age_q <= age_q + 1'b1;
   end

   // a column pulse from the open page costs the accept cycle, the setup
   // cycle, T_CAS strobe cycles and one more open cycle before closing
   assign hit_ok = (int'(age_q) + T_CAS + 3) <= T_RAS_MAX;

endmodule

// File: rtl/dramc_ctrl.sv
module dramc_ctrl
   import dramc_pkg::*;
#(
   parameter int ROW_BITS         = 10,
   parameter int COL_BITS         = 10,
   parameter int DATA_W           = 16,
   parameter int T_RCD            = 3,
   parameter int T_CAS            = 2,
   parameter int T_RP             = 3,
   parameter int T_RAS_MAX        = 1000,
   parameter int REFRESH_INTERVAL = 780
) (
   input  logic                                              clk,
   input  logic                                              rst_n,
   input  logic                                              req_valid,
   output logic                                              req_ready,
   input  logic                                              req_write,
   input  logic [ROW_BITS+COL_BITS-1:0]                      req_addr,
   input  logic [DATA_W-1:0]                                 req_wdata,
   output logic                                              rsp_valid,
   output logic [DATA_W-1:0]                                 rsp_rdata,
   output logic [(ROW_BITS > COL_BITS ? ROW_BITS : COL_BITS)-1:0] dram_addr,
   output logic                                              dram_ras_n,
   output logic                                              dram_cas_n,
   output logic                                              dram_we_n,
   output logic                                              dram_dq_oe,
   output logic [DATA_W-1:0]                                 dram_dq_out,
   input  logic [DATA_W-1:0]                                 dram_dq_in
);

   localparam int AW        = ROW_BITS + COL_BITS;
   localparam int PIN_W     = max2(ROW_BITS, COL_BITS);
   localparam int T_REF_LOW = T_RCD + T_CAS;
   localparam int CNT_MAX   = max2(max2(T_RCD, T_CAS), max2(T_RP, T_REF_LOW));
   localparam int CNT_W     = $clog2(CNT_MAX + 1);

   generate
      if (T_RCD < 1 || T_CAS < 1 || T_RP < 1) begin : g_bad_timing
         $error("dramc_ctrl: timing counts must be at least one cycle");
      end
      if (T_RAS_MAX < T_RCD + T_CAS + 3) begin : g_bad_ras_max
         $error("dramc_ctrl: T_RAS_MAX too small for one access");
      end
      if (REFRESH_INTERVAL < 2 * (T_RAS_MAX + T_RP + 4)) begin : g_bad_refresh
         $error("dramc_ctrl: refresh interval shorter than worst page hold");
      end
      if (ROW_BITS < 1 || COL_BITS < 1 || DATA_W < 1) begin : g_bad_width
         $error("dramc_ctrl: widths must be positive");
      end
   endgenerate

   dramc_state_e        state_q;
   logic                is_ref_q;
   logic                wr_q;
   logic [ROW_BITS-1:0] row_q;
   logic [COL_BITS-1:0] col_q;
   logic [DATA_W-1:0]   wdata_q;

   logic [ROW_BITS-1:0] req_row, ref_row, row_src;
   logic [COL_BITS-1:0] req_col, col_src;
   logic [PIN_W-1:0]    row_pins, col_pins;

   logic ref_pending, ref_take, ref_done;
   logic hit, hit_ok, accept, close_page;
   logic cnt_load, cnt_zero;
   logic [CNT_W-1:0] cnt_val;

   assign req_row = req_addr[AW-1:COL_BITS];
   assign req_col = req_addr[COL_BITS-1:0];
   assign row_src = ref_pending ? ref_row : req_row;
   assign col_src = (state_q == ST_OPEN) ? req_col : col_q;

   // zero-extend whichever half is narrower than the shared pins
   generate
      if (ROW_BITS == PIN_W) begin : g_row_full
         assign row_pins = row_src;
      end else begin : g_row_pad
         assign row_pins = {{(PIN_W - ROW_BITS){1'b0}}, row_src};
      end
      if (COL_BITS == PIN_W) begin : g_col_full
         assign col_pins = col_src;
      end else begin : g_col_pad
         assign col_pins = {{(PIN_W - COL_BITS){1'b0}}, col_src};
      end
   endgenerate

   dramc_refresh_sched #(
      .INTERVAL (REFRESH_INTERVAL),
      .ROW_BITS (ROW_BITS)
   ) u_refresh (
      .clk     (clk),
      .rst_n   (rst_n),
      .take    (ref_take),
      .done    (ref_done),
      .pending (ref_pending),
      .row     (ref_row)
   );

   dramc_ras_age #(
      .T_RAS_MAX (T_RAS_MAX),
      .T_CAS     (T_CAS)
   ) u_age (
      .clk    (clk),
      .rst_n  (rst_n),
      .ras_n  (dram_ras_n),
      .hit_ok (hit_ok)
   );

   dramc_wait_cnt #(
      .MAX_LOAD  (CNT_MAX),
      .RESET_VAL (T_RP - 1)
   ) u_wait (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (cnt_load),
      .load_val (cnt_val),
      .zero     (cnt_zero)
   );

   assign hit        = (req_row == row_q);
   assign req_ready  = !ref_pending &&
                       ((state_q == ST_IDLE) || (state_q == ST_OPEN && hit && hit_ok));
   assign accept     = req_valid && req_ready;
   assign close_page = (state_q == ST_OPEN) &&
                       (ref_pending || !hit_ok || (req_valid && !hit));

   always_comb begin
      cnt_load = 1'b0;
      cnt_val  = '0;
      ref_take = 1'b0;
      ref_done = 1'b0;
      unique case (state_q)
         ST_IDLE:   ref_take = ref_pending;
         ST_RSETUP: begin
            cnt_load = 1'b1;
            cnt_val  = is_ref_q ? CNT_W'(T_REF_LOW - 1) : CNT_W'(T_RCD - 1);
         end
         ST_CSETUP: begin
            cnt_load = 1'b1;
            cnt_val  = CNT_W'(T_CAS - 1);
         end
         ST_OPEN: begin
            cnt_load = close_page;
            cnt_val  = CNT_W'(T_RP - 1);
         end
         ST_REF: begin
            cnt_load = cnt_zero;
            ref_done = cnt_zero;
            cnt_val  = CNT_W'(T_RP - 1);
         end
         default: ;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q     <= ST_PRE;
         is_ref_q    <= 1'b0;
         wr_q        <= 1'b0;
         row_q       <= '0;
         col_q       <= '0;
         wdata_q     <= '0;
         dram_addr   <= '0;
         dram_ras_n  <= 1'b1;
         dram_cas_n  <= 1'b1;
         dram_we_n   <= 1'b1;
         dram_dq_oe  <= 1'b0;
         dram_dq_out <= '0;
         rsp_valid   <= 1'b0;
         rsp_rdata   <= '0;
      end else begin
         rsp_valid <= 1'b0;
         unique case (state_q)
            ST_PRE: if (cnt_zero) state_q <= ST_IDLE;
            ST_IDLE: begin
               if (ref_pending) begin
                  is_ref_q  <= 1'b1;
                  dram_addr <= row_pins;
                  state_q   <= ST_RSETUP;
               end else if (accept) begin
                  is_ref_q  <= 1'b0;
                  row_q     <= req_row;
                  col_q     <= req_col;
                  wr_q      <= req_write;
                  wdata_q   <= req_wdata;
                  dram_addr <= row_pins;
                  state_q   <= ST_RSETUP;
               end
            end
            ST_RSETUP: begin
               dram_ras_n <= 1'b0;
               state_q    <= is_ref_q ? ST_REF : ST_ROW;
            end
            ST_ROW: if (cnt_zero) begin
               dram_addr   <= col_pins;
               dram_we_n   <= !wr_q;
               dram_dq_oe  <= wr_q;
               dram_dq_out <= wdata_q;
               state_q     <= ST_CSETUP;
            end
            ST_CSETUP: begin
               dram_cas_n <= 1'b0;
               state_q    <= ST_COL;
            end
            ST_COL: if (cnt_zero) begin
               dram_cas_n <= 1'b1;
               dram_we_n  <= 1'b1;
               dram_dq_oe <= 1'b0;
               if (!wr_q) begin
                  rsp_rdata <= dram_dq_in;
                  rsp_valid <= 1'b1;
               end
               state_q <= ST_OPEN;
            end
            ST_OPEN: begin
               if (close_page) begin
                  dram_ras_n <= 1'b1;
                  state_q    <= ST_PRE;
               end else if (accept) begin
                  col_q       <= req_col;
                  wr_q        <= req_write;
                  wdata_q     <= req_wdata;
                  dram_addr   <= col_pins;
                  dram_we_n   <= !req_write;
                  dram_dq_oe  <= req_write;
                  dram_dq_out <= req_wdata;
                  state_q     <= ST_CSETUP;
               end
            end
            ST_REF: if (cnt_zero) begin
               dram_ras_n <= 1'b1;
               state_q    <= ST_PRE;
            end
            default: state_q <= ST_PRE;
         endcase
      end
   end

endmodule

// File: rtl/dramc_ctrl_chk.sv
module dramc_ctrl_chk #(
   parameter int PIN_W     = 10,
   parameter int T_RCD     = 3,
   parameter int T_RP      = 3,
   parameter int T_RAS_MAX = 1000
) (
   input logic             clk,
   input logic             rst_n,
   input logic             dram_ras_n,
   input logic             dram_cas_n,
   input logic             dram_we_n,
   input logic             dram_dq_oe,
   input logic [PIN_W-1:0] dram_addr,
   input logic             rsp_valid
);

   localparam int LW = $clog2(T_RAS_MAX + 2) + 1;
   localparam int HW = $clog2(T_RP + 1) + 1;

   logic [LW-1:0] lo_cnt;
   logic [HW-1:0] hi_cnt;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         lo_cnt <= '0;
         hi_cnt <= '0;
      end else begin
         if (dram_ras_n) lo_cnt <= '0;
         else if (lo_cnt != '1) lo_cnt <= lo_cnt + 1'b1;
         if (!dram_ras_n) hi_cnt <= '0;
         else if (hi_cnt != '1) hi_cnt <= hi_cnt + 1'b1;
      end
   end

   AST_PRECHARGE_MIN: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(dram_ras_n) |-> (hi_cnt >= HW'(T_RP)));                          // R2
   AST_ROW_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(dram_ras_n) |-> $stable(dram_addr));                             // R2
   AST_CAS_INSIDE_RAS: assert property (@(posedge clk) disable iff (!rst_n)
      !dram_cas_n |-> !dram_ras_n);                                          // R3
   AST_CAS_AFTER_RCD: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(dram_cas_n) |-> (lo_cnt >= LW'(T_RCD)));                         // R3
   AST_COL_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(dram_cas_n) |-> $stable(dram_addr));                             // R3
   AST_WRITE_SETUP: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(dram_cas_n) && !dram_we_n) |-> ($past(dram_we_n) == 1'b0 && dram_dq_oe)); // R4
   AST_WE_INSIDE_RAS: assert property (@(posedge clk) disable iff (!rst_n)
      !dram_we_n |-> !dram_ras_n);                                           // R4
   AST_RVALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |=> !rsp_valid);                                             // R5
   AST_RAS_LOW_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      !dram_ras_n |-> (lo_cnt < LW'(T_RAS_MAX)));                            // R10

endmodule

bind dramc_ctrl dramc_ctrl_chk #(
   .PIN_W     ((ROW_BITS > COL_BITS) ? ROW_BITS : COL_BITS),
   .T_RCD     (T_RCD),
   .T_RP      (T_RP),
   .T_RAS_MAX (T_RAS_MAX)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .dram_ras_n (dram_ras_n),
   .dram_cas_n (dram_cas_n),
   .dram_we_n  (dram_we_n),
   .dram_dq_oe (dram_dq_oe),
   .dram_addr  (dram_addr),
   .rsp_valid  (rsp_valid)
);

// File: tb/dramc_ctrl_bench.sv
`timescale 1ns/1ps
module dramc_ctrl_bench;

   localparam int RB = 4, CB = 4, DW = 8;
   localparam int T_RCD = 2, T_CAS = 2, T_RP = 3, T_RAS_MAX = 20, RI = 150;

   logic clk = 1'b0, rst_n = 1'b0;
   logic req_valid = 1'b0, req_write = 1'b0;
   logic [RB+CB-1:0] req_addr = '0;
   logic [DW-1:0] req_wdata = '0;
   logic req_ready, rsp_valid;
   logic [DW-1:0] rsp_rdata, dram_dq_out, dram_dq_in;
   logic [3:0] dram_addr;
   logic dram_ras_n, dram_cas_n, dram_we_n, dram_dq_oe;

   always #2.5 clk = ~clk;

   dramc_ctrl #(
      .ROW_BITS(RB), .COL_BITS(CB), .DATA_W(DW), .T_RCD(T_RCD), .T_CAS(T_CAS),
      .T_RP(T_RP), .T_RAS_MAX(T_RAS_MAX), .REFRESH_INTERVAL(RI)
   ) u_dramc_ctrl (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
      .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .dram_addr(dram_addr),
      .dram_ras_n(dram_ras_n), .dram_cas_n(dram_cas_n), .dram_we_n(dram_we_n),
      .dram_dq_oe(dram_dq_oe), .dram_dq_out(dram_dq_out), .dram_dq_in(dram_dq_in)
   );

   // behavioural memory on the pins
   logic [DW-1:0] mem [256];
   logic [DW-1:0] ref_mem [256];
   logic [3:0] row_l = '0, col_l = '0;

   always @(negedge dram_ras_n) row_l = dram_addr;
   always @(negedge dram_cas_n) begin
      col_l = dram_addr;
      if (!dram_we_n) mem[{row_l, dram_addr}] = dram_dq_out;
   end
   assign dram_dq_in = (!dram_cas_n && dram_we_n) ? mem[{row_l, col_l}] : '0;

   int checks = 0, failures = 0;
   int cyc = 0, run_count = 0, ref_count = 0, rsp_cnt = 0;
   int q_row[$], q_col[$], q_wr[$], q_dat[$];

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s at cycle %0d: actual=%0d expected=%0d", req, cyc, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   endtask

   // per-clock protocol reference
   initial begin
      bit prev_ras = 1, prev_cas = 1, prev_we = 1, prev_rv = 0, cas_seen = 0, rdy_in_run = 0;
      logic [3:0] prev_addr = '0;
      int hi_run = 0, lo_run = 0, ras_fall_cyc = 0, run_row = 0;
      int exp_ref_row = 0, last_ref_cyc = 0;
      bit rsp_on = 0;
      int rsp_cyc = 0, rsp_dat = 0;
      forever begin
         @(negedge clk); #2;
         if (rst_n) begin
            cyc++;
            if (prev_ras && !dram_ras_n) begin
               chk(dram_addr == prev_addr, "R2 row addr stable", dram_addr, prev_addr);
               chk(hi_run >= T_RP, "R2 precharge", hi_run, T_RP);
               chk(dram_cas_n == 1'b1, "R3 cas high at ras fall", dram_cas_n, 1);
               run_row = dram_addr; cas_seen = 0; rdy_in_run = 0; lo_run = 0;
               ras_fall_cyc = cyc; run_count++;
            end
            if (!dram_ras_n) begin
               lo_run++;
               chk(lo_run <= T_RAS_MAX, "R10 ras low length", lo_run, T_RAS_MAX);
               if (req_ready) rdy_in_run = 1;
            end else begin
               hi_run++;
               chk(dram_cas_n == 1'b1, "R3 cas outside ras", dram_cas_n, 1);
            end
            if (prev_cas && !dram_cas_n) begin
               cas_seen = 1;
               chk(cyc - ras_fall_cyc >= T_RCD, "R3 rcd", cyc - ras_fall_cyc, T_RCD);
               chk(dram_addr == prev_addr, "R3 col addr stable", dram_addr, prev_addr);
               if (q_row.size() == 0) chk(0, "R11 unexpected column access", 1, 0);
               else begin
                  int er, ec, ew, ed;
                  er = q_row.pop_front(); ec = q_col.pop_front();
                  ew = q_wr.pop_front();  ed = q_dat.pop_front();
                  chk(run_row == er, "R11 row", run_row, er);
                  chk(dram_addr == ec, "R11 column", dram_addr, ec);
                  if (ew != 0) begin
                     chk(!dram_we_n && !prev_we && dram_dq_oe, "R4 write enables", dram_we_n, 0);
                     chk(dram_dq_out == ed, "R4 write data", dram_dq_out, ed);
                  end else begin
                     chk(dram_we_n == 1'b1, "R4 read has we high", dram_we_n, 1);
                     rsp_on = 1; rsp_cyc = cyc + T_CAS; rsp_dat = ed;
                  end
               end
            end
            if (rsp_valid) begin
               chk(rsp_on && cyc == rsp_cyc, "R5 rvalid timing", cyc, rsp_cyc);
               chk(rsp_rdata == rsp_dat, "R5 read data", rsp_rdata, rsp_dat);
               chk(!prev_rv, "R5 single pulse", prev_rv, 0);
               rsp_on = 0; rsp_cnt++;
            end else if (rsp_on && cyc > rsp_cyc) begin
               chk(0, "R5 missing rvalid", 0, 1); rsp_on = 0;
            end
            if (!prev_ras && dram_ras_n) begin
               hi_run = 1;
               if (!cas_seen) begin
                  chk(run_row == exp_ref_row, "R8 refresh row", run_row, exp_ref_row);
                  chk(cyc - last_ref_cyc <= RI + T_RAS_MAX + T_RP + 10, "R8 refresh period",
                      cyc - last_ref_cyc, RI);
                  chk(!rdy_in_run, "R9 ready during refresh", rdy_in_run, 0);
                  exp_ref_row = (exp_ref_row + 1) % (1 << RB);
                  last_ref_cyc = cyc; ref_count++;
               end
            end
            if (!dram_we_n) chk(!dram_ras_n, "R4 we outside ras", dram_ras_n, 0);
            prev_ras = dram_ras_n; prev_cas = dram_cas_n; prev_we = dram_we_n;
            prev_rv = rsp_valid; prev_addr = dram_addr;
         end
      end
   end

   task automatic host_req(input bit wr, input int row, input int col, input int data);
      bit done = 0;
      int idx, target;
      idx = row * 16 + col;
      @(negedge clk);
      req_valid = 1; req_write = wr; req_addr = 8'(idx); req_wdata = 8'(data);
      while (!done) begin
         #1;
         if (req_ready) begin
            q_row.push_back(row); q_col.push_back(col); q_wr.push_back(int'(wr));
            q_dat.push_back(wr ? data : int'(ref_mem[idx]));
            if (wr) ref_mem[idx] = 8'(data);
            done = 1;
         end else @(negedge clk);
      end
      target = rsp_cnt + 1;
      @(negedge clk);
      req_valid = 0;
      if (!wr) wait (rsp_cnt >= target);
   endtask

   task automatic wait_refresh();
      int r0;
      r0 = ref_count;
      wait (ref_count > r0);
   endtask

   initial begin
      #400000;
      chk(0, "watchdog", cyc, 0);
      finish_run();
   end

   initial begin
      int r0;
      for (int i = 0; i < 256; i++) begin
         mem[i] = 8'(i * 37 + 5);
         ref_mem[i] = 8'(i * 37 + 5);
      end
      repeat (4) @(negedge clk);
      chk(dram_ras_n && dram_cas_n && dram_we_n, "R1 strobes in reset", {dram_ras_n, dram_cas_n}, 3);
      chk(!dram_dq_oe && !rsp_valid, "R1 outputs in reset", dram_dq_oe, 0);
      rst_n = 1;
      @(negedge clk); #1;
      chk(dram_ras_n && dram_cas_n && dram_we_n && !dram_dq_oe, "R1 after reset", dram_ras_n, 1);

      wait_refresh();
      r0 = run_count;
      host_req(1, 5, 1, 8'hA5);
      host_req(0, 5, 1, 0);
      host_req(0, 5, 2, 0);
      chk(run_count - r0 == 1, "R6 page hit keeps row open", run_count - r0, 1);

      r0 = run_count;
      host_req(0, 9, 3, 0);
      chk(run_count - r0 == 1, "R7 miss reopens row", run_count - r0, 1);

      wait_refresh();
      r0 = run_count;
      for (int c = 0; c < 6; c++) host_req(0, 2, c, 0);
      chk(run_count - r0 >= 2, "R10 page force-closed", run_count - r0, 2);

      host_req(1, 15, 15, 8'h3C);
      host_req(1, 0, 0, 8'hC3);
      host_req(1, 15, 0, 8'h00);
      host_req(1, 0, 15, 8'hFF);
      host_req(0, 15, 15, 0);
      host_req(0, 0, 0, 0);
      host_req(0, 15, 0, 0);
      host_req(0, 0, 15, 0);
      for (int k = 0; k < 12; k++) host_req(k[0], (k * 5) % 16, (k * 3) % 16, k * 19);

      while (ref_count < 4) @(negedge clk);
      chk(ref_count >= 4, "R8 refreshes keep coming", ref_count, 4);
      chk(q_row.size() == 0, "R11 all requests served", q_row.size(), 0);
      repeat (10) @(negedge clk);
      finish_run();
   end

endmodule